// File: doc/BRIEF.md
# Paged Word Address Pointer

This block keeps the word address that a paged serial memory uses for its next byte access. A protocol engine around it loads a new address when the bus master supplies one, and strobes an advance after each data byte. The register output drives the storage array directly. The pointer keeps its value between transactions, so a read that supplies no address carries on from the byte after the last one accessed.

The way the pointer advances depends on the kind of access. In write mode only the offset bits inside a page count up. A burst that runs past the end of a page starts again at the first byte of that same page and overwrites it. In read mode the whole address counts up, and it wraps from the top of the array back to zero. `ARRAY_DEPTH` sets the size of the array and `PAGE_BYTES` sets the size of a page. Both must be powers of two.

The load address comes in two fields. The page-select field forms the most significant bits. It arrives with the device-select byte. The eight-bit word field forms the low bits.

Top module: `page_word_pointer`

## Requirements
- R1: While `rstN` is low, and in the cycle after its release, `curAddr` is 0.
- R2: When `loadEn` is high at a rising clock edge, `curAddr` equals `{loadPage, loadWord}` after that edge. `loadPage` forms bits 10..8 and `loadWord` forms bits 7..0 (defaults).
- R3: When `stepEn` is high and `writeMode` is 1, only the low log2(`PAGE_BYTES`) bits of `curAddr` count up by one. For example 0x12E becomes 0x12F. The bits above them are held.
- R4: A write-mode step from the last byte of a page goes to the first byte of the same page. With 16-byte pages, 0x12F becomes 0x120.
- R5: When `stepEn` is high and `writeMode` is 0, the whole `curAddr` counts up by one and carries across page boundaries. For example 0x12F becomes 0x130.
- R6: A read-mode step from the last address (0x7FF) goes to 0x000.
- R7: With both `loadEn` and `stepEn` low, `curAddr` keeps its value for any number of cycles. The value of `writeMode` has no effect while the strobes are low.
- R8: When `loadEn` and `stepEn` are both high in the same cycle, the load wins and the step is discarded.
- R9: With `PAGE_BYTES` = 8, write-mode steps change only bits 2..0. For example 0x12F becomes 0x128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load the pointer from `loadPage`/`loadWord` |
| loadPage | input | ADDR_W-8 (3) | Page-select bits, most significant part of the address |
| loadWord | input | 8 | Word-address byte, low part of the address |
| stepEn | input | 1 | Advance the pointer by one byte |
| writeMode | input | 1 | 1: wrap within the page, 0: wrap across the whole array |
| curAddr | output | ADDR_W (11) | Current word address to the storage array |

## Verification
A load and a step can arrive in the same cycle. This happens when a new address is presented just as the previous byte is acknowledged. The bench raises both strobes on the same edge, in both write and read mode. It then expects the loaded address alone, with no increment applied. Stepping the loaded address afterwards confirms that the step was discarded and not merely delayed.

// File: rtl/page_word_pointer_pkg.sv
package page_word_pointer_pkg;

  // Strobes passed from the control decode to the address datapath
  typedef struct packed {
    logic load;      // take the external address
    logic step;      // advance by one byte
    logic pageWrap;  // advance only the in-page offset
  } ptrCtl_t;

endpackage

// File: rtl/ptr_ctl.sv
module ptr_ctl
  import page_word_pointer_pkg::*;
(
  input  logic    loadEn,
  input  logic    stepEn,
  input  logic    writeMode,
  output ptrCtl_t ctl
);

  // A load overrides a step that arrives in the same cycle
  always_comb begin
    ctl.load     = loadEn;
    ctl.step     = stepEn & ~loadEn;
    ctl.pageWrap = writeMode;
  end

endmodule

// File: rtl/ptr_datapath.sv
module ptr_datapath
  import page_word_pointer_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrCtl_t           ctl,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic [ADDR_W-1:0] addrQ
);

  logic [ADDR_W-1:0] linearInc;
  logic [ADDR_W-1:0] pageInc;
  logic [ADDR_W-1:0] nextAddr;

  assign linearInc = addrQ + ADDR_W'(1);

  generate
    if (PAGE_W == 0) begin : g_bytePage
      assign pageInc = addrQ;
    end else if (PAGE_W >= ADDR_W) begin : g_wholePage
      assign pageInc = linearInc;
    end else begin : g_splitPage
      logic [PAGE_W-1:0] offsetInc;
      assign offsetInc = addrQ[PAGE_W-1:0] + PAGE_W'(1);
      assign pageInc   = {addrQ[ADDR_W-1:PAGE_W], offsetInc};
    end
  endgenerate

  always_comb begin
    nextAddr = addrQ;
    if (ctl.load)      nextAddr = loadAddr;
    else if (ctl.step) nextAddr = ctl.pageWrap ? pageInc : linearInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else       addrQ <= nextAddr;
  end

  // R1
  p_reset_zero_r1: assert property (@(posedge clk) !rstN |=> addrQ == '0);

  // R2
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> addrQ == $past(loadAddr));

  // R5
  p_read_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.pageWrap) |=> addrQ == $past(addrQ) + ADDR_W'(1));

  // R7
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(addrQ));

  generate
    if (PAGE_W > 0 && PAGE_W < ADDR_W) begin : g_pageChk
      // R3
      p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.step && ctl.pageWrap) |=>
          addrQ[ADDR_W-1:PAGE_W] == $past(addrQ[ADDR_W-1:PAGE_W]));
      // R4
      p_offset_step_r4: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.step && ctl.pageWrap) |=>
          addrQ[PAGE_W-1:0] == $past(addrQ[PAGE_W-1:0]) + PAGE_W'(1));
    end
  endgenerate

endmodule

// File: rtl/page_word_pointer.sv
module page_word_pointer
  import page_word_pointer_pkg::*;
#(
  parameter int ARRAY_DEPTH = 2048,
  parameter int PAGE_BYTES  = 16,
  parameter int WORD_W      = 8,
  localparam int ADDR_W     = $clog2(ARRAY_DEPTH),
  localparam int PAGE_W     = $clog2(PAGE_BYTES),
  localparam int SEL_W      = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [SEL_W-1:0]  loadPage,
  input  logic [WORD_W-1:0] loadWord,
  input  logic              stepEn,
  input  logic              writeMode,
  output logic [ADDR_W-1:0] curAddr
);

  ptrCtl_t ctl;

  ptr_ctl u_ctl (
    .loadEn    (loadEn),
    .stepEn    (stepEn),
    .writeMode (writeMode),
    .ctl       (ctl)
  );

  ptr_datapath #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .loadAddr ({loadPage, loadWord}),
    .addrQ    (curAddr)
  );

  // R8: a load alongside a step yields exactly the loaded address
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && stepEn) |=> curAddr == $past({loadPage, loadWord}));

endmodule

// File: tb/page_word_pointer_bench.sv
module page_word_pointer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [2:0]  loadPage = '0;
  logic [7:0]  loadWord = '0;
  logic        stepEn = 1'b0;
  logic        writeMode = 1'b0;
  logic [10:0] curAddr;
  logic [10:0] curAddr8;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  page_word_pointer u_page_word_pointer (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadPage(loadPage),
    .loadWord(loadWord), .stepEn(stepEn), .writeMode(writeMode),
    .curAddr(curAddr)
  );

  page_word_pointer #(.PAGE_BYTES(8)) u_page_word_pointer_p8 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadPage(loadPage),
    .loadWord(loadWord), .stepEn(stepEn), .writeMode(writeMode),
    .curAddr(curAddr8)
  );

  task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%03h expected 0x%03h", tag, got, exp);
    end
  endtask

  // Drive one cycle of strobes, then sample one edge later
  task automatic cycle(input logic ld, input logic [10:0] addr, input logic st, input logic wm);
    @(negedge clk);
    loadEn = ld; {loadPage, loadWord} = addr; stepEn = st; writeMode = wm;
    @(negedge clk);
    loadEn = 1'b0; stepEn = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", curAddr, 11'h000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", curAddr, 11'h000);
  endtask

  task automatic t_load();
    cycle(1'b1, 11'h5A3, 1'b0, 1'b0);
    check("R2 load 0x5A3", curAddr, 11'h5A3);
    cycle(1'b1, {3'b110, 8'h01}, 1'b0, 1'b1);
    check("R2 page field on top", curAddr, 11'h601);
  endtask

  task automatic t_write_step();
    cycle(1'b1, 11'h12E, 1'b0, 1'b1);
    cycle(1'b0, 11'h000, 1'b1, 1'b1);
    check("R3 write step", curAddr, 11'h12F);
  endtask

  task automatic t_write_wrap();
    cycle(1'b0, 11'h000, 1'b1, 1'b1);
    check("R4 write wrap", curAddr, 11'h120);
    cycle(1'b1, 11'h7FF, 1'b0, 1'b1);
    cycle(1'b0, 11'h000, 1'b1, 1'b1);
    check("R4 write wrap top page", curAddr, 11'h7F0);
  endtask

  task automatic t_read_step();
    cycle(1'b1, 11'h12F, 1'b0, 1'b0);
    cycle(1'b0, 11'h000, 1'b1, 1'b0);
    check("R5 read carry", curAddr, 11'h130);
    cycle(1'b1, 11'h0FF, 1'b0, 1'b0);
    cycle(1'b0, 11'h000, 1'b1, 1'b0);
    check("R5 read across word byte", curAddr, 11'h100);
  endtask

  task automatic t_read_wrap();
    cycle(1'b1, 11'h7FF, 1'b0, 1'b0);
    cycle(1'b0, 11'h000, 1'b1, 1'b0);
    check("R6 read wrap", curAddr, 11'h000);
  endtask

  task automatic t_hold();
    cycle(1'b1, 11'h2C4, 1'b0, 1'b0);
    @(negedge clk); writeMode = 1'b1;
    repeat (5) @(negedge clk);
    writeMode = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 hold", curAddr, 11'h2C4);
    cycle(1'b0, 11'h000, 1'b1, 1'b0);
    check("R7 continue after hold", curAddr, 11'h2C5);
  endtask

  task automatic t_priority();
    cycle(1'b1, 11'h100, 1'b0, 1'b0);
    cycle(1'b1, 11'h3AF, 1'b1, 1'b1);
    check("R8 load wins write", curAddr, 11'h3AF);
    cycle(1'b1, 11'h455, 1'b1, 1'b0);
    check("R8 load wins read", curAddr, 11'h455);
    cycle(1'b0, 11'h000, 1'b1, 1'b0);
    check("R8 step not delayed", curAddr, 11'h456);
  endtask

  task automatic t_page8();
    cycle(1'b1, 11'h12E, 1'b0, 1'b1);
    cycle(1'b0, 11'h000, 1'b1, 1'b1);
    check("R9 8-byte step", curAddr8, 11'h12F);
    check("R3 16-byte step", curAddr, 11'h12F);
    cycle(1'b0, 11'h000, 1'b1, 1'b1);
    check("R9 8-byte wrap", curAddr8, 11'h128);
    check("R4 16-byte wrap", curAddr, 11'h120);
    cycle(1'b0, 11'h000, 1'b1, 1'b0);
    check("R9 read unaffected", curAddr8, 11'h129);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_load();
    t_write_step();
    t_write_wrap();
    t_read_step();
    t_read_wrap();
    t_hold();
    t_priority();
    t_page8();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule